// File: doc/BRIEF.md
# Write-Bypassing Register File

This block is the architectural register store of a pipelined processor. It has one write port, used by the write-back stage, and two independent combinational read ports, used by the decode stage. In the default ordering the write-back update is treated as happening before the decode reads of the same cycle. A read whose address matches the write in flight gets the incoming data at once, so decode never sees a value that is one cycle stale.

The legal register numbers run from a low bound to a high bound, both parameters. The address width and the data width are parameters too. A register number outside the range reads as zero, and a write to it is dropped. An ordering parameter picks the other behaviour, reads before the update, for in-order pipelines. In that mode the read ports show only what the storage array held at the last clock edge. In both modes the array changes only at the clock edge.

Top module: `wbrf_top`

## Requirements
- R1: After reset every in-range register reads zero on both ports.
- R2: A write with `wr_en` high to an in-range address is visible on any read port of that address from the next cycle on.
- R3: With ORDER = WR_BEFORE_RD, a read port whose address equals an in-range write address in the same cycle returns `wr_data` combinationally in that cycle.
- R4: A read port whose address differs from the write address returns the stored contents of its own register during the write cycle.
- R5: With ORDER = RD_BEFORE_WR, a read of the address being written returns the value held before that write. The new value appears from the next cycle.
- R6: A read address below LO or above HI returns zero in both modes, even while that address is being written.
- R7: A write to an address outside LO..HI changes no register.
- R8: The two read ports are independent. Each one applies R3 to R6 to its own address in the same cycle.
- R9: With `wr_en` low, no register changes and nothing is forwarded, whatever `wr_addr` and `wr_data` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears all registers |
| wr_en | input | 1 | Write request from write-back |
| wr_addr | input | ADDR_W | Register number to write |
| wr_data | input | DATA_W | Value to write |
| rd0_addr | input | ADDR_W | Register number for read port 0 |
| rd0_data | output | DATA_W | Read port 0 data, combinational |
| rd1_addr | input | ADDR_W | Register number for read port 1 |
| rd1_data | output | DATA_W | Read port 1 data, combinational |

## Verification
The bench runs two instances side by side, one in each ordering, under the same stimulus.

- **Same-address cycles** read the register being written. Each instance must then give a different answer: the fresh data in one, the old contents in the other. This tells the bypass apart from plain storage.
- **Different-address cycles and split ports** put one port on the write address and the other elsewhere. These show that matching is done per port and does not leak across ports.
- **Addresses at the range edges** use LO, HI and the values just outside them, with writes that are disabled or out of range. A full read-back afterwards shows that nothing was stored.
- **A long random mix** is checked against a reference array kept in the bench.

// File: rtl/wbrf_pkg.sv
`timescale 1ns/1ps
package wbrf_pkg;

  typedef enum logic {
    WR_BEFORE_RD = 1'b0,
    RD_BEFORE_WR = 1'b1
  } order_e;

  function automatic logic addr_ok(input logic [31:0] a,
                                   input int unsigned lo,
                                   input int unsigned hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic logic [31:0] addr_off(input logic [31:0] a,
                                           input int unsigned lo);
    return a - lo;
  endfunction

endpackage

// File: rtl/wbrf_wire.sv
`timescale 1ns/1ps
module wbrf_wire
  import wbrf_pkg::*;
#(
  parameter int          ADDR_W = 5,
  parameter int          DATA_W = 32,
  parameter int unsigned LO     = 4,
  parameter int unsigned HI     = 27,
  parameter int          IDX_W  = 5
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              set_vld,
  output logic [IDX_W-1:0]  set_idx,
  output logic [DATA_W-1:0] set_data
);
  logic wr_in_rng;

  always_comb begin
    wr_in_rng = addr_ok(32'(wr_addr), LO, HI);
    set_vld   = wr_en && wr_in_rng;
    set_idx   = IDX_W'(addr_off(32'(wr_addr), LO));
    set_data  = wr_data;
  end
endmodule

// File: rtl/wbrf_store.sv
`timescale 1ns/1ps
module wbrf_store #(
  parameter int          DATA_W = 32,
  parameter int unsigned DEPTH  = 24,
  parameter int          IDX_W  = 5,
  parameter int          NRD    = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        set_vld,
  input  logic [IDX_W-1:0]            set_idx,
  input  logic [DATA_W-1:0]           set_data,
  input  logic [NRD-1:0][IDX_W-1:0]   rd_idx,
  output logic [NRD-1:0][DATA_W-1:0]  rd_q
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
    end else if (set_vld && (32'(set_idx) < DEPTH)) begin
      mem[set_idx] <= set_data;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (32'(rd_idx[p]) < DEPTH) rd_q[p] = mem[rd_idx[p]];
      else                        rd_q[p] = '0;
    end
  end

  for (genvar i = 0; i < int'(DEPTH); i++) begin : g_ent
    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vld && set_idx == IDX_W'(i)) |=> mem[i] == $past(set_data))
      else $error("write_lands_chk entry %0d", i);
    // R7 R9
    entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_vld && set_idx == IDX_W'(i)) |=> $stable(mem[i]))
      else $error("entry_hold_chk entry %0d", i);
  end
endmodule

// File: rtl/wbrf_rdport.sv
`timescale 1ns/1ps
module wbrf_rdport
  import wbrf_pkg::*;
#(
  parameter int          ADDR_W = 5,
  parameter int          DATA_W = 32,
  parameter int unsigned LO     = 4,
  parameter int unsigned HI     = 27,
  parameter int          IDX_W  = 5,
  parameter order_e      ORDER  = WR_BEFORE_RD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] stored,
  input  logic              set_vld,
  input  logic [IDX_W-1:0]  set_idx,
  input  logic [DATA_W-1:0] set_data,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic rd_in_rng;
  logic fwd_hit;

  always_comb begin
    rd_in_rng = addr_ok(32'(rd_addr), LO, HI);
    rd_idx    = IDX_W'(addr_off(32'(rd_addr), LO));
    fwd_hit   = set_vld && rd_in_rng && (set_idx == rd_idx);
  end

  if (ORDER == WR_BEFORE_RD) begin : g_wbr
    always_comb begin
      if (!rd_in_rng)   rd_data = '0;
      else if (fwd_hit) rd_data = set_data;
      else              rd_data = stored;
    end
    // R3
    fwd_commits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_hit |=> (!$stable(rd_addr) || stored == $past(rd_data)))
      else $error("fwd_commits_chk");
  end else begin : g_rbw
    always_comb begin
      if (!rd_in_rng) rd_data = '0;
      else            rd_data = stored;
    end
    // R5
    old_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_in_rng |-> rd_data == stored)
      else $error("old_value_chk");
  end

  // R6
  out_of_range_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_in_rng |-> rd_data == '0)
    else $error("out_of_range_zero_chk");
endmodule

// File: rtl/wbrf_top.sv
`timescale 1ns/1ps
module wbrf_top
  import wbrf_pkg::*;
#(
  parameter int          ADDR_W = 5,
  parameter int          DATA_W = 32,
  parameter int unsigned LO     = 4,
  parameter int unsigned HI     = 27,
  parameter order_e      ORDER  = WR_BEFORE_RD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd0_addr,
  output logic [DATA_W-1:0] rd0_data,
  input  logic [ADDR_W-1:0] rd1_addr,
  output logic [DATA_W-1:0] rd1_data
);
  localparam int unsigned DEPTH = HI - LO + 1;
  localparam int          IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int          NRD   = 2;

  logic                       set_vld;
  logic [IDX_W-1:0]           set_idx;
  logic [DATA_W-1:0]          set_data;
  logic [NRD-1:0][ADDR_W-1:0] rd_addr_a;
  logic [NRD-1:0][IDX_W-1:0]  rd_idx_a;
  logic [NRD-1:0][DATA_W-1:0] rd_q_a;
  logic [NRD-1:0][DATA_W-1:0] rd_data_a;

  assign rd_addr_a[0] = rd0_addr;
  assign rd_addr_a[1] = rd1_addr;
  assign rd0_data     = rd_data_a[0];
  assign rd1_data     = rd_data_a[1];

  wbrf_wire #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LO(LO), .HI(HI), .IDX_W(IDX_W)
  ) u_wire (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .set_vld(set_vld), .set_idx(set_idx), .set_data(set_data)
  );

  wbrf_store #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W), .NRD(NRD)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .set_vld(set_vld), .set_idx(set_idx), .set_data(set_data),
    .rd_idx(rd_idx_a), .rd_q(rd_q_a)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_port
    wbrf_rdport #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LO(LO), .HI(HI),
      .IDX_W(IDX_W), .ORDER(ORDER)
    ) u_rd (
      .clk(clk), .rst_n(rst_n),
      .rd_addr(rd_addr_a[p]), .stored(rd_q_a[p]),
      .set_vld(set_vld), .set_idx(set_idx), .set_data(set_data),
      .rd_idx(rd_idx_a[p]), .rd_data(rd_data_a[p])
    );
  end

  // R9
  no_write_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> !set_vld)
    else $error("no_write_no_fwd_chk");
endmodule

// File: tb/tb_wbrf_top.sv
`timescale 1ns/1ps
module tb_wbrf_top;
  import wbrf_pkg::*;

  localparam int          AW = 5;
  localparam int          DW = 32;
  localparam int unsigned LO = 4;
  localparam int unsigned HI = 27;

  typedef struct {
    string       tag;
    logic [DW-1:0] ea0, ea1, eb0, eb1;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd0_addr = '0, rd1_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] a0, a1, b0, b1;

  int checks = 0, fails = 0;
  bit done = 0;
  exp_t sb[$];
  logic [DW-1:0] refm [32];

  always #10 clk = ~clk;

  wbrf_top #(.ADDR_W(AW), .DATA_W(DW), .LO(LO), .HI(HI), .ORDER(WR_BEFORE_RD)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd0_addr(rd0_addr), .rd0_data(a0), .rd1_addr(rd1_addr), .rd1_data(a1));

  wbrf_top #(.ADDR_W(AW), .DATA_W(DW), .LO(LO), .HI(HI), .ORDER(RD_BEFORE_WR)) dut_rbw (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd0_addr(rd0_addr), .rd0_data(b0), .rd1_addr(rd1_addr), .rd1_data(b1));

  function automatic bit legal(input logic [AW-1:0] a);
    return (int'(a) >= int'(LO)) && (int'(a) <= int'(HI));
  endfunction

  function automatic logic [DW-1:0] exp_wbr(input logic we, input logic [AW-1:0] wa,
      input logic [DW-1:0] wd, input logic [AW-1:0] ra);
    if (!legal(ra)) return '0;
    if (we && legal(wa) && wa == ra) return wd;
    return refm[ra];
  endfunction

  function automatic logic [DW-1:0] exp_rbw(input logic [AW-1:0] ra);
    return legal(ra) ? refm[ra] : '0;
  endfunction

  task automatic chk(input string tag, input string port,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, port, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                      input logic [AW-1:0] r0, input logic [AW-1:0] r1, input string tag);
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; rd0_addr = r0; rd1_addr = r1;
    e.tag = tag;
    e.ea0 = exp_wbr(we, wa, wd, r0);
    e.ea1 = exp_wbr(we, wa, wd, r1);
    e.eb0 = exp_rbw(r0);
    e.eb1 = exp_rbw(r1);
    sb.push_back(e);
    if (we && legal(wa)) refm[wa] = wd;
  endtask

  // monitor: samples mid-low-phase, before the next rising edge
  initial begin
    forever begin
      exp_t e;
      @(negedge clk);
      #5;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        chk(e.tag, "wbr port0", a0, e.ea0);
        chk(e.tag, "wbr port1", a1, e.ea1);
        chk(e.tag, "rbw port0", b0, e.eb0);
        chk(e.tag, "rbw port1", b1, e.eb1);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: got hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) refm[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents, in-range edges included
    for (int a = int'(LO); a <= int'(HI); a += 2)
      step(1'b0, '0, '0, AW'(a), AW'(a + 1), "R1 reset");

    // R2: write then read next cycle
    step(1'b1, 5'd5, 32'hCAFE_0005, 5'd6, 5'd7, "R2 write");
    step(1'b0, 5'd0, 32'h0, 5'd5, 5'd5, "R2 readback");
    step(1'b1, 5'd12, 32'h1234_5678, 5'd5, 5'd4, "R2 write");
    step(1'b0, 5'd0, 32'h0, 5'd12, 5'd5, "R2 readback");

    // R3 R5: same-address write/read, both ports
    step(1'b1, 5'd5, 32'hAAAA_5555, 5'd5, 5'd5, "R3 R5 same addr");
    step(1'b0, 5'd0, 32'h0, 5'd5, 5'd12, "R5 next cycle");
    step(1'b1, 5'd4, 32'h0000_0044, 5'd4, 5'd4, "R3 R5 low edge");
    step(1'b1, 5'd27, 32'h2727_2727, 5'd27, 5'd27, "R3 R5 high edge");

    // R4: write while reading other addresses
    step(1'b1, 5'd10, 32'hDEAD_BEEF, 5'd12, 5'd5, "R4 diff addr");
    step(1'b0, 5'd0, 32'h0, 5'd10, 5'd11, "R4 readback");

    // R8: one port on the write address, the other elsewhere
    step(1'b1, 5'd12, 32'h0BAD_F00D, 5'd12, 5'd10, "R8 split ports");
    step(1'b1, 5'd10, 32'h1010_1010, 5'd12, 5'd10, "R8 split ports");

    // R6: out-of-range reads, also while writing those addresses
    step(1'b0, 5'd0, 32'h0, 5'd0, 5'd31, "R6 out of range");
    step(1'b1, 5'd3, 32'hFFFF_FFFF, 5'd3, 5'd28, "R6 R7 oor write");
    step(1'b1, 5'd28, 32'hEEEE_EEEE, 5'd28, 5'd3, "R6 R7 oor write");

    // R9: disabled write carries data to a live address
    step(1'b0, 5'd5, 32'h9999_9999, 5'd5, 5'd6, "R9 disabled write");
    step(1'b0, 5'd0, 32'h0, 5'd5, 5'd6, "R9 readback");

    // R7: full read-back shows nothing landed from oor writes
    for (int a = 0; a < 32; a += 2)
      step(1'b0, '0, '0, AW'(a), AW'(a + 1), "R7 sweep");

    // random mix against the reference array
    for (int n = 0; n < 400; n++)
      step(1'($urandom), AW'($urandom), $urandom, AW'($urandom), AW'($urandom), "R3 R4 R5 R8 mix");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule